// File: doc/BRIEF.md
# Packet Buffer CPU Access Port

This block gives a processor word-wide access to the per-pipe packet buffers of a USB device controller. Software writes a selection register to choose a pipe, the direction of the data movement (the CPU writes IN data or reads OUT data) and the access width. A ready flag in the control/status register shows when the selected buffer may be used. A data register then moves two bytes per access, or a single byte when software has narrowed a write. Each pipe's buffer is a small byte memory with its own fill count and read pointer, so software can switch pipes in the middle of a transfer and later resume on a pipe without loss.

On the serial side, a simple fill/drain interface stands in for the USB engine. It can append received bytes to a pipe and mark the packet complete. It can also peek at a committed packet byte by byte and then release it. Software commits IN packets explicitly: as a short packet, as a zero-length packet, or automatically when the packet reaches its maximum size. Software may also discard a received packet without reading it.

Top module: `usb_fifo_port`

## Requirements
- R1: After reset the selection register reads 0, and the status register reads 0 (not ready, no error, byte count 0).
- R2: Selection register (address 0): bits [PIPE_W-1:0] hold the pipe number, bit 5 holds the direction (1 = CPU writes), and bit 10 holds the 16-bit width enable. It reads back as written, with all other bits 0.
- R3: A selection write that changes the pipe or the direction holds the ready flag low for exactly SETTLE cycles. A write that changes only the width leaves the flag unaffected.
- R4: Status register (address 1) bit 13 is the ready flag. After settling it is 1 on a CPU-write pipe whose buffer is not committed, and 1 on a CPU-read pipe whose buffer holds a complete received packet.
- R5: A data write (address 2) with the width bit set stores bits 7:0, then bits 15:8, at the next two byte positions and adds 2 to the count. With the width bit clear it stores only bits 7:0 and adds 1.
- R6: Data reads are always 16 bits wide, with the earlier byte in bits 7:0. An odd final byte returns with bits 15:8 = 0. The read that consumes the last byte releases the buffer (count 0, not ready).
- R7: Status bits 9:0 give the byte count of the selected pipe's buffer.
- R8: On a CPU-write pipe, writing status bit 15 commits the buffer as a packet of the current count. Writing bits 15 and 14 together commits a zero-length packet.
- R9: On a CPU-read pipe, writing bit 14 alone discards the received packet without reading it.
- R10: A data access made while not ready, or in the wrong direction, changes no buffer state and sets the sticky error flag (status bit 12). Writing 1 to bit 12 clears it.
- R11: A data write that brings the count to MAX_PKT commits the packet without the commit bit.
- R12: Each pipe keeps its own count, so a pipe that is selected again continues filling where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_re_i | input | 1 | Register read strobe (data reads advance the pointer) |
| cpu_addr_i | input | 2 | Register address: 0 select, 1 control/status, 2 data |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data (combinational) |
| usb_pipe_i | input | PIPE_W | Pipe addressed by the serial side |
| usb_fill_i | input | 1 | Append usb_byte_i to the pipe buffer |
| usb_byte_i | input | 8 | Received byte |
| usb_end_i | input | 1 | Mark the received packet complete |
| usb_drain_i | input | 1 | Release a committed packet |
| usb_idx_i | input | IDX_W | Byte index to peek |
| usb_byte_o | output | 8 | Buffer byte at usb_idx_i |
| usb_len_o | output | CNT_W | Byte count of the addressed pipe |
| usb_full_o | output | 1 | Addressed pipe holds a committed/complete packet |

## Verification
The assertions assume that the serial side never works on the pipe that a CPU data access touches in the same cycle, and that it fills only CPU-read pipes and drains only committed CPU-write pipes. The bench keeps to this by running serial-side actions only between CPU accesses, and only on pipes in the matching state. It also keeps random packet lengths below the buffer size, except in the directed test of the automatic commit.

// File: rtl/usb_fifo_port_pkg.sv
package usb_fifo_port_pkg;
  typedef enum logic [1:0] {
    REG_SEL = 2'd0,
    REG_CTL = 2'd1,
    REG_DAT = 2'd2
  } reg_e;

  localparam int unsigned SelDirBit  = 5;
  localparam int unsigned SelWideBit = 10;
  localparam int unsigned CtlCommit  = 15;
  localparam int unsigned CtlClear   = 14;
  localparam int unsigned CtlReady   = 13;
  localparam int unsigned CtlErr     = 12;
endpackage

// File: rtl/usb_fifo_settle.sv
module usb_fifo_settle #(
  parameter int unsigned SETTLE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned SW = $clog2(SETTLE + 1);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= SW'(SETTLE);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r3_settle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/usb_fifo_pipe_buf.sv
module usb_fifo_pipe_buf #(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned MAX_PKT   = 64,
  localparam int unsigned IDX_W    = $clog2(BUF_BYTES),
  localparam int unsigned CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_word_i,
  input  logic [15:0]      wdata_i,
  input  logic             rd_i,
  input  logic             commit_i,
  input  logic             zlp_i,
  input  logic             clear_i,
  input  logic             fill_i,
  input  logic [7:0]       fill_byte_i,
  input  logic             end_i,
  input  logic             drain_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic [15:0]      rword_o,
  output logic [7:0]       byte_o
);
  logic [7:0]       mem [BUF_BYTES];
  logic [CNT_W-1:0] cnt_q, rptr_q;
  logic             full_q;
  logic [CNT_W:0]   wr_next, rp1, rp2, fill_next;
  logic [CNT_W-1:0] wr_next_sat;

  always_comb begin
    wr_next     = {1'b0, cnt_q} + (wr_word_i ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    wr_next_sat = (wr_next > (CNT_W+1)'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : wr_next[CNT_W-1:0];
    fill_next   = {1'b0, cnt_q} + 1'b1;
    rp1         = {1'b0, rptr_q} + 1'b1;
    rp2         = {1'b0, rptr_q} + (CNT_W+1)'(2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; rptr_q <= '0; full_q <= 1'b0;
    end else if (clear_i || drain_i) begin
      cnt_q <= '0; rptr_q <= '0; full_q <= 1'b0;
    end else if (commit_i) begin
      full_q <= 1'b1;
      if (zlp_i) cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wr_next_sat;
      if (wr_next >= (CNT_W+1)'(MAX_PKT)) full_q <= 1'b1;
    end else if (rd_i) begin
      if (rp2 >= {1'b0, cnt_q}) begin
        cnt_q <= '0; rptr_q <= '0; full_q <= 1'b0;
      end else begin
        rptr_q <= rp2[CNT_W-1:0];
      end
    end else if (fill_i) begin
      if (fill_next <= (CNT_W+1)'(BUF_BYTES)) cnt_q <= fill_next[CNT_W-1:0];
    end else if (end_i) begin
      full_q <= 1'b1; rptr_q <= '0;
    end
  end

  // Byte storage, no reset
  always_ff @(posedge clk_i) begin
    if (!(clear_i || drain_i || commit_i)) begin
      if (wr_i) begin
        if (cnt_q < CNT_W'(BUF_BYTES)) mem[cnt_q[IDX_W-1:0]] <= wdata_i[7:0];
        if (wr_word_i && (fill_next < (CNT_W+1)'(BUF_BYTES)))
          mem[fill_next[IDX_W-1:0]] <= wdata_i[15:8];
      end else if (!rd_i && fill_i && cnt_q < CNT_W'(BUF_BYTES)) begin
        mem[cnt_q[IDX_W-1:0]] <= fill_byte_i;
      end
    end
  end

  assign rword_o[7:0]  = (rptr_q < cnt_q) ? mem[rptr_q[IDX_W-1:0]] : 8'h00;
  assign rword_o[15:8] = (rp1 < {1'b0, cnt_q}) ? mem[rp1[IDX_W-1:0]] : 8'h00;
  assign byte_o = mem[idx_i];
  assign cnt_o  = cnt_q;
  assign full_o = full_q;

  a_r11_auto_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i && !drain_i && !commit_i && wr_next >= (CNT_W+1)'(MAX_PKT)) |=> full_q);
  a_r9_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && !full_q));
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUF_BYTES));
endmodule

// File: rtl/usb_fifo_port.sv
module usb_fifo_port
  import usb_fifo_port_pkg::*;
#(
  parameter int unsigned NUM_PIPES = 4,
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned MAX_PKT   = 64,
  parameter int unsigned SETTLE    = 3,
  localparam int unsigned PIPE_W   = $clog2(NUM_PIPES),
  localparam int unsigned IDX_W    = $clog2(BUF_BYTES),
  localparam int unsigned CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [15:0]       cpu_wdata_i,
  output logic [15:0]       cpu_rdata_o,
  input  logic [PIPE_W-1:0] usb_pipe_i,
  input  logic              usb_fill_i,
  input  logic [7:0]        usb_byte_i,
  input  logic              usb_end_i,
  input  logic              usb_drain_i,
  input  logic [IDX_W-1:0]  usb_idx_i,
  output logic [7:0]        usb_byte_o,
  output logic [CNT_W-1:0]  usb_len_o,
  output logic              usb_full_o
);
  logic [PIPE_W-1:0] sel_pipe_q;
  logic              sel_dir_q, sel_wide_q, err_q;
  logic              sel_we, ctl_we, dat_we, dat_re, reselect;
  logic              settle_done, ready, wr_ok, rd_ok, bad, commit, clear;
  logic [CNT_W-1:0]  cnt   [NUM_PIPES];
  logic              full  [NUM_PIPES];
  logic [15:0]       rword [NUM_PIPES];
  logic [7:0]        ubyte [NUM_PIPES];
  logic [15:0]       sel_rd, stat_rd;

  assign sel_we = cpu_we_i && cpu_addr_i == REG_SEL;
  assign ctl_we = cpu_we_i && cpu_addr_i == REG_CTL;
  assign dat_we = cpu_we_i && cpu_addr_i == REG_DAT;
  assign dat_re = cpu_re_i && cpu_addr_i == REG_DAT;
  assign reselect = sel_we && ((cpu_wdata_i[PIPE_W-1:0] != sel_pipe_q) ||
                               (cpu_wdata_i[SelDirBit] != sel_dir_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_pipe_q <= '0; sel_dir_q <= 1'b0; sel_wide_q <= 1'b0;
    end else if (sel_we) begin
      sel_pipe_q <= cpu_wdata_i[PIPE_W-1:0];
      sel_dir_q  <= cpu_wdata_i[SelDirBit];
      sel_wide_q <= cpu_wdata_i[SelWideBit];
    end
  end

  usb_fifo_settle #(.SETTLE(SETTLE)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(reselect), .done_o(settle_done)
  );

  assign ready  = settle_done && (sel_dir_q ? !full[sel_pipe_q] : full[sel_pipe_q]);
  assign wr_ok  = dat_we && ready && sel_dir_q;
  assign rd_ok  = dat_re && ready && !sel_dir_q;
  assign bad    = (dat_we || dat_re) && !(wr_ok || rd_ok);
  assign commit = ctl_we && cpu_wdata_i[CtlCommit] && sel_dir_q && !full[sel_pipe_q];
  assign clear  = ctl_we && cpu_wdata_i[CtlClear] && !cpu_wdata_i[CtlCommit] && !sel_dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              err_q <= 1'b0;
    else if (bad)                             err_q <= 1'b1;
    else if (ctl_we && cpu_wdata_i[CtlErr])   err_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
    logic hit, uhit;
    assign hit  = (sel_pipe_q == PIPE_W'(g));
    assign uhit = (usb_pipe_i == PIPE_W'(g));
    usb_fifo_pipe_buf #(.BUF_BYTES(BUF_BYTES), .MAX_PKT(MAX_PKT)) u_buf (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(wr_ok && hit), .wr_word_i(sel_wide_q), .wdata_i(cpu_wdata_i),
      .rd_i(rd_ok && hit), .commit_i(commit && hit),
      .zlp_i(cpu_wdata_i[CtlClear]), .clear_i(clear && hit),
      .fill_i(usb_fill_i && uhit), .fill_byte_i(usb_byte_i),
      .end_i(usb_end_i && uhit), .drain_i(usb_drain_i && uhit),
      .idx_i(usb_idx_i), .cnt_o(cnt[g]), .full_o(full[g]),
      .rword_o(rword[g]), .byte_o(ubyte[g])
    );
  end

  always_comb begin
    sel_rd = '0;
    sel_rd[PIPE_W-1:0] = sel_pipe_q;
    sel_rd[SelDirBit]  = sel_dir_q;
    sel_rd[SelWideBit] = sel_wide_q;
    stat_rd = '0;
    stat_rd[9:0]      = 10'(cnt[sel_pipe_q]);
    stat_rd[CtlReady] = ready;
    stat_rd[CtlErr]   = err_q;
    case (cpu_addr_i)
      REG_SEL: cpu_rdata_o = sel_rd;
      REG_CTL: cpu_rdata_o = stat_rd;
      REG_DAT: cpu_rdata_o = sel_dir_q ? 16'h0000 : rword[sel_pipe_q];
      default: cpu_rdata_o = 16'h0000;
    endcase
  end

  assign usb_byte_o = ubyte[usb_pipe_i];
  assign usb_len_o  = cnt[usb_pipe_i];
  assign usb_full_o = full[usb_pipe_i];

  a_r3_reselect_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reselect |=> !ready);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(ctl_we && cpu_wdata_i[CtlErr])) |=> err_q);
  a_r10_bad_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> err_q);
  a_r10_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dat_we || dat_re) && !ready && !usb_fill_i && !usb_end_i && !usb_drain_i)
      |=> $stable(cnt[sel_pipe_q]));
endmodule

// File: tb/usb_fifo_port_bench.sv
module usb_fifo_port_bench;
  localparam int NP = 4, BB = 64, MP = 64, ST = 3;
  logic clk = 0, rst_ni = 0;
  logic we = 0, re = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0] upipe = 0;
  logic ufill = 0, uend = 0, udrain = 0;
  logic [7:0] ubyte_in = 0, ubyte_out;
  logic [5:0] uidx = 0;
  logic [6:0] ulen;
  logic ufull;
  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [BB];

  always #5 clk = ~clk;

  usb_fifo_port #(.NUM_PIPES(NP), .BUF_BYTES(BB), .MAX_PKT(MP), .SETTLE(ST)) u_usb_fifo_port (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_we_i(we), .cpu_re_i(re), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .usb_pipe_i(upipe), .usb_fill_i(ufill),
    .usb_byte_i(ubyte_in), .usb_end_i(uend), .usb_drain_i(udrain), .usb_idx_i(uidx),
    .usb_byte_o(ubyte_out), .usb_len_o(ulen), .usb_full_o(ufull));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [15:0] stat_exp(input bit rdy, input bit err, input int cnt);
    return 16'((rdy << 13) | (err << 12) | cnt);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  task automatic sel(input int p, input bit dir, input bit wide);
    wr(2'd0, 16'(p | (dir << 5) | (wide << 10)));
  endtask

  task automatic settle(); repeat (ST + 1) @(posedge clk); endtask

  task automatic ufill_pkt(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); upipe = 2'(p); ufill = 1; ubyte_in = 8'($urandom); mdl[i] = ubyte_in;
      @(posedge clk); #1 ufill = 0;
    end
    @(negedge clk); upipe = 2'(p); uend = 1;
    @(posedge clk); #1 uend = 0;
  endtask

  task automatic udrain_pkt(input int p);
    @(negedge clk); upipe = 2'(p); udrain = 1;
    @(posedge clk); #1 udrain = 0;
  endtask

  task automatic check_pkt(input int p, input int n, input string req);
    bit ok = 1;
    @(negedge clk); upipe = 2'(p); #1;
    chk(ufull == 1, req, ufull, 1);
    chk(ulen == 7'(n), req, ulen, n);
    for (int i = 0; i < n; i++) begin
      uidx = 6'(i); #1;
      if (ubyte_out != mdl[i]) begin ok = 0; chk(0, req, ubyte_out, mdl[i]); end
    end
    if (ok) chk(1, req, 0, 0);
  endtask

  initial begin
    #2000000; $display("FAIL watchdog actual=0 expected=1"); n_fail++; n_chk++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk); $finish;
  end

  initial begin
    logic [15:0] v;
    int n, nw, ptr;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk); #1 rst_ni = 1;
    // R1
    rd(2'd1, v); chk(v == 16'h0, "R1", v, 0);
    rd(2'd0, v); chk(v == 16'h0, "R1", v, 0);
    // R2, R3
    sel(1, 1, 1);
    rd(2'd0, v); chk(v == 16'h0421, "R2", v, 16'h0421);
    for (int i = 0; i < ST - 1; i++) begin
      rd(2'd1, v); chk(v[13] == 0, "R3", v[13], 0);
    end
    rd(2'd1, v); chk(v[13] == 1, "R3 R4", v[13], 1);
    // R5, R7, R8 random short packets on pipe 1
    for (int it = 0; it < 8; it++) begin
      n = 1 + ($urandom % 40);
      sel(1, 1, 1);
      for (int i = 0; i < n / 2; i++) begin
        v = 16'($urandom); mdl[2*i] = v[7:0]; mdl[2*i+1] = v[15:8]; wr(2'd2, v);
      end
      if (n % 2) begin
        sel(1, 1, 0);
        rd(2'd1, v); chk(v[13] == 1, "R3", v[13], 1);
        v = 16'($urandom); mdl[n-1] = v[7:0]; wr(2'd2, v);
      end
      rd(2'd1, v); chk(v == stat_exp(1, 0, n), "R5 R7", v, stat_exp(1, 0, n));
      wr(2'd1, 16'h8000);
      rd(2'd1, v); chk(v == stat_exp(0, 0, n), "R4 R8", v, stat_exp(0, 0, n));
      check_pkt(1, n, "R5 R8");
      udrain_pkt(1);
    end
    // R8 zero-length
    sel(1, 1, 1);
    wr(2'd2, 16'hbeef);
    wr(2'd1, 16'hc000);
    @(negedge clk); upipe = 1; #1;
    chk(ufull == 1 && ulen == 0, "R8", {ufull, ulen}, 16'h80);
    udrain_pkt(1);
    // R11 automatic commit
    for (int i = 0; i < MP / 2; i++) begin
      v = 16'($urandom); mdl[2*i] = v[7:0]; mdl[2*i+1] = v[15:8]; wr(2'd2, v);
    end
    rd(2'd1, v); chk(v == stat_exp(0, 0, MP), "R11", v, stat_exp(0, 0, MP));
    check_pkt(1, MP, "R11");
    udrain_pkt(1);
    // R4, R6 reads on pipe 2
    sel(2, 0, 1); settle();
    rd(2'd1, v); chk(v[13] == 0, "R4", v[13], 0);
    for (int it = 0; it < 8; it++) begin
      n = 1 + ($urandom % 40);
      ufill_pkt(2, n);
      rd(2'd1, v); chk(v == stat_exp(1, 0, n), "R4 R7", v, stat_exp(1, 0, n));
      nw = (n + 1) / 2;
      for (int i = 0; i < nw; i++) begin
        logic [15:0] e;
        ptr = 2 * i;
        e = {(ptr + 1 < n) ? mdl[ptr+1] : 8'h00, mdl[ptr]};
        rd(2'd2, v); chk(v == e, "R6", v, e);
      end
      rd(2'd1, v); chk(v == 16'h0, "R6", v, 0);
    end
    // R9 discard
    ufill_pkt(2, 5);
    wr(2'd1, 16'h4000);
    rd(2'd1, v); chk(v == 16'h0, "R9", v, 0);
    // R10 bad accesses
    rd(2'd2, v);
    rd(2'd1, v); chk(v == stat_exp(0, 1, 0), "R10", v, stat_exp(0, 1, 0));
    wr(2'd1, 16'h1000);
    rd(2'd1, v); chk(v == 16'h0, "R10", v, 0);
    sel(1, 1, 1);
    wr(2'd2, 16'h1234);
    settle();
    rd(2'd1, v); chk(v == stat_exp(1, 1, 0), "R10", v, stat_exp(1, 1, 0));
    wr(2'd1, 16'h1000);
    // R12 resume after switching pipes
    wr(2'd2, 16'h0100); wr(2'd2, 16'h0302);
    sel(3, 1, 1); settle();
    wr(2'd2, 16'haa55);
    sel(1, 1, 1); settle();
    rd(2'd1, v); chk(v == stat_exp(1, 0, 4), "R12", v, stat_exp(1, 0, 4));
    wr(2'd2, 16'h0504);
    wr(2'd1, 16'h8000);
    for (int i = 0; i < 6; i++) mdl[i] = 8'(i);
    check_pkt(1, 6, "R12");
    sel(3, 1, 1); settle();
    rd(2'd1, v); chk(v == stat_exp(1, 0, 2), "R12", v, stat_exp(1, 0, 2));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule